// File: doc/BRIEF.md
# Center-Aligned PWM ADC Trigger Generator

This block raises start-of-conversion pulses for an analog-to-digital converter from a triangle-wave carrier. An external counter climbs from 0 to a crest value and falls back. The block watches that counter and its direction. It has two independent channels, A and B. Each channel compares the counter with its own working compare value and emits a single-clock request when the two are equal. A request is issued only while the counter sits inside a window that the channel has enabled.

Software writes a buffer value for each channel. The working value is refreshed from the buffer on a chosen carrier event: the crest, the trough, both, or never. In plain (non-complementary) operation the refresh instead follows an external period-match strobe. Because the refresh lands one clock after the strobe, some buffer values miss a trigger for one phase. The requests can also be tied to an external qualify input that comes from interrupt-skipping logic. When a tied channel holds a compare value that the skipping scheme cannot reach, the block raises a configuration-error flag.

Top module: `adc_trig_gen`

## Requirements
- R1: A request output goes high for exactly the clock after a cycle in which the counter equals that channel's working value inside an enabled window. It is low in every other cycle.
- R2: In complementary mode the up enable opens the window only when `cnt_up`=1 and the counter lies in 0 to crest−1 inclusive.
- R3: In complementary mode the down enable opens the window only when `cnt_up`=0 and the counter lies in 1 to crest inclusive.
- R4: In plain mode (`comp_mode`=0) the down enables have no effect, and the up enable matches in either count direction.
- R5: In complementary mode the reload select in control bits 15:14 works as follows: 00 never reloads, 01 reloads on `crest_stb`, 10 reloads on `trough_stb`, 11 reloads on either strobe.
- R6: In plain mode select 01 reloads on `period_stb`. Selects 10 and 11 never reload.
- R7: A reload copies the buffer into the working value in the clock after the strobe, so the compare in the strobe cycle still uses the old value. In one case the buffer is 0, the reload is at the trough and the up enable is set; in the other the buffer equals the crest, the reload is at the crest and the down enable is set. In both cases no request is issued in the phase that follows the reload, and the next period does fire.
- R8: Control bits 3:2 tie channel A, and bits 1:0 tie channel B, to the qualify input (`skip_ok_a` / `skip_ok_b`). A tied channel issues a request only while its qualify input is 1.
- R9: `cfg_err` is 1 exactly when a tied channel's working value is below 2 or above crest−2.
- R10: The control word is written as a whole. The enable bits are: bit 7 up A, bit 6 down A, bit 5 up B, bit 4 down B. Bits 13:8 always read as 0.
- R11: After reset all registers are 0, both request outputs are low and `cfg_err` is low.
- R12: The register addresses are 0 control, 1 buffer A, 2 buffer B, 3 working A and 4 working B. Each address can be both written and read. A write to a working value takes priority over a reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_mode | input | 1 | 1 = complementary (triangle) mode, 0 = plain mode |
| cnt_val | input | 16 | Carrier counter value |
| cnt_up | input | 1 | 1 while the counter is in its up phase |
| crest_val | input | 16 | Crest value of the carrier |
| crest_stb | input | 1 | High in the cycle the counter is at the crest |
| trough_stb | input | 1 | High in the cycle the counter is at the trough |
| period_stb | input | 1 | Period compare-match strobe for plain mode |
| skip_ok_a | input | 1 | Qualify input for channel A |
| skip_ok_b | input | 1 | Qualify input for channel B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| trig_a | output | 1 | Channel A start request |
| trig_b | output | 1 | Channel B start request |
| cfg_err | output | 1 | Tied channel holds an unreachable compare value |

## Verification
The assertions assume that the carrier is well formed. The crest and trough strobes must coincide with the counter at the crest and at 0, and `cnt_up` must be 0 at the crest and 1 at the trough. The stimulus meets this by generating every carrier period in the bench itself: a triangle in complementary mode, and a rising or falling sawtooth with `period_stb` at its top in plain mode. The crest value is kept at 4 or more. Random register writes land anywhere in the period, including on strobe cycles, so the assertions must also hold when a write and a reload coincide.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int REG_W = 16;
    localparam logic [REG_W-1:0] CTRL_MASK = 16'hC0FF;

    typedef enum logic [1:0] {
        RL_NEVER  = 2'b00,
        RL_CREST  = 2'b01,
        RL_TROUGH = 2'b10,
        RL_BOTH   = 2'b11
    } reload_sel_e;

    typedef enum logic [2:0] {
        AD_CTRL   = 3'd0,
        AD_BUF_A  = 3'd1,
        AD_BUF_B  = 3'd2,
        AD_WORK_A = 3'd3,
        AD_WORK_B = 3'd4
    } reg_addr_e;

    typedef struct packed {
        reload_sel_e sel;
        logic        up_a;
        logic        dn_a;
        logic        up_b;
        logic        dn_b;
        logic [1:0]  tie_a;
        logic [1:0]  tie_b;
    } ctrl_t;

    typedef struct packed {
        logic up_en;
        logic down_en;
        logic tied;
    } chan_cfg_t;

    function automatic ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        c.sel   = reload_sel_e'(w[15:14]);
        c.up_a  = w[7];
        c.dn_a  = w[6];
        c.up_b  = w[5];
        c.dn_b  = w[4];
        c.tie_a = w[3:2];
        c.tie_b = w[1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c);
        return {c.sel, 6'b000000, c.up_a, c.dn_a, c.up_b, c.dn_b, c.tie_a, c.tie_b};
    endfunction

    function automatic chan_cfg_t chan_cfg(ctrl_t c, logic pick_b);
        chan_cfg_t r;
        r.up_en   = pick_b ? c.up_b : c.up_a;
        r.down_en = pick_b ? c.dn_b : c.dn_a;
        r.tied    = pick_b ? |c.tie_b : |c.tie_a;
        return r;
    endfunction

    function automatic logic reload_due(reload_sel_e sel, logic comp,
                                        logic at_crest, logic at_trough,
                                        logic at_period);
        logic due;
        if (comp) begin
            unique case (sel)
                RL_CREST:  due = at_crest;
                RL_TROUGH: due = at_trough;
                RL_BOTH:   due = at_crest | at_trough;
                default:   due = 1'b0;
            endcase
        end else begin
            due = (sel == RL_CREST) && at_period;
        end
        return due;
    endfunction

endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
    import adc_trig_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic [DW-1:0]    work_a_i,
    input  logic [DW-1:0]    work_b_i,
    output ctrl_t            ctrl_o,
    output logic [DW-1:0]    buf_a_o,
    output logic [DW-1:0]    buf_b_o,
    output logic             load_a_o,
    output logic             load_b_o,
    output logic [DW-1:0]    load_data_o
);

    ctrl_t         ctrl_q;
    logic [DW-1:0] buf_a_q;
    logic [DW-1:0] buf_b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            buf_a_q <= '0;
            buf_b_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                AD_CTRL:  ctrl_q  <= unpack_ctrl(wr_data);
                AD_BUF_A: buf_a_q <= wr_data[DW-1:0];
                AD_BUF_B: buf_b_q <= wr_data[DW-1:0];
                default:  ;
            endcase
        end
    end

    assign load_a_o    = wr_en && (wr_addr == AD_WORK_A);
    assign load_b_o    = wr_en && (wr_addr == AD_WORK_B);
    assign load_data_o = wr_data[DW-1:0];
    assign ctrl_o      = ctrl_q;
    assign buf_a_o     = buf_a_q;
    assign buf_b_o     = buf_b_q;

    always_comb begin
        case (rd_addr)
            AD_CTRL:   rd_data = pack_ctrl(ctrl_q);
            AD_BUF_A:  rd_data = REG_W'(buf_a_q);
            AD_BUF_B:  rd_data = REG_W'(buf_b_q);
            AD_WORK_A: rd_data = REG_W'(work_a_i);
            AD_WORK_B: rd_data = REG_W'(work_b_i);
            default:   rd_data = '0;
        endcase
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == AD_CTRL) |-> (rd_data[13:8] == 6'b000000)) else $error("reserved bits set"); // R10

    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AD_CTRL) |=> (pack_ctrl(ctrl_o) == ($past(wr_data) & CTRL_MASK))) else $error("ctrl write lost"); // R10

endmodule

// File: rtl/adc_trig_chan.sv
module adc_trig_chan
    import adc_trig_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          comp_mode_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          cnt_up_i,
    input  logic [CW-1:0] crest_i,
    input  logic          reload_i,
    input  logic [CW-1:0] buf_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_data_i,
    input  chan_cfg_t     cfg_i,
    input  logic          skip_ok_i,
    output logic          trig_o,
    output logic [CW-1:0] work_o,
    output logic          err_o
);

    localparam int XW = CW + 1;

    logic [CW-1:0] work_q;
    logic          trig_q;
    logic [XW-1:0] cnt_x, crest_x, work_x;
    logic          up_win, dn_win, hit;

    assign cnt_x   = {1'b0, cnt_i};
    assign crest_x = {1'b0, crest_i};
    assign work_x  = {1'b0, work_q};

    always_comb begin
        up_win = comp_mode_i ? (cnt_up_i && (cnt_x + XW'(1) <= crest_x)) : 1'b1;
        dn_win = comp_mode_i && !cnt_up_i && (cnt_i != '0) && (cnt_x <= crest_x);
        hit    = ((cfg_i.up_en && up_win) || (cfg_i.down_en && dn_win))
                 && (cnt_i == work_q)
                 && (!cfg_i.tied || skip_ok_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= hit;
            if (load_i)
                work_q <= load_data_i;
            else if (reload_i)
                work_q <= buf_i;
        end
    end

    assign trig_o = trig_q;
    assign work_o = work_q;
    assign err_o  = cfg_i.tied && ((work_x < XW'(2)) || (work_x + XW'(2) > crest_x));

    AST_TRIG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> $past(cfg_i.up_en || cfg_i.down_en)) else $error("request without enable"); // R1

    AST_PLAIN_DOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!comp_mode_i && !cfg_i.up_en) |=> !trig_o) else $error("down enable used in plain mode"); // R4

    AST_RELOAD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (reload_i && !load_i) |=> (work_o == $past(buf_i))) else $error("reload mistimed"); // R7

    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!reload_i && !load_i) |=> $stable(work_o)) else $error("working value drifted"); // R5

    AST_TIED_NEEDS_QUALIFY: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> $past(!cfg_i.tied || skip_ok_i)) else $error("tied request without qualify"); // R8

    AST_TROUGH_DOWN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (comp_mode_i && !cnt_up_i && cnt_i == '0 && !cfg_i.up_en) |=> !trig_o) else $error("down window hit at zero"); // R3

endmodule

// File: rtl/adc_trig_gen.sv
module adc_trig_gen
    import adc_trig_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             comp_mode,
    input  logic [CW-1:0]    cnt_val,
    input  logic             cnt_up,
    input  logic [CW-1:0]    crest_val,
    input  logic             crest_stb,
    input  logic             trough_stb,
    input  logic             period_stb,
    input  logic             skip_ok_a,
    input  logic             skip_ok_b,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             trig_a,
    output logic             trig_b,
    output logic             cfg_err
);

    localparam int NCH = 2;

    ctrl_t         ctrl;
    logic [CW-1:0] buf_w   [NCH];
    logic [CW-1:0] work_w  [NCH];
    logic          load_w  [NCH];
    logic          skip_w  [NCH];
    logic          trig_w  [NCH];
    logic          err_w   [NCH];
    chan_cfg_t     cfg_w   [NCH];
    logic [CW-1:0] load_data;
    logic          reload;

    adc_trig_regs #(.DW(CW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .work_a_i    (work_w[0]),
        .work_b_i    (work_w[1]),
        .ctrl_o      (ctrl),
        .buf_a_o     (buf_w[0]),
        .buf_b_o     (buf_w[1]),
        .load_a_o    (load_w[0]),
        .load_b_o    (load_w[1]),
        .load_data_o (load_data)
    );

    assign reload    = reload_due(ctrl.sel, comp_mode, crest_stb, trough_stb, period_stb);
    assign skip_w[0] = skip_ok_a;
    assign skip_w[1] = skip_ok_b;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign cfg_w[g] = chan_cfg(ctrl, g[0]);

        adc_trig_chan #(.CW(CW)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .comp_mode_i (comp_mode),
            .cnt_i       (cnt_val),
            .cnt_up_i    (cnt_up),
            .crest_i     (crest_val),
            .reload_i    (reload),
            .buf_i       (buf_w[g]),
            .load_i      (load_w[g]),
            .load_data_i (load_data),
            .cfg_i       (cfg_w[g]),
            .skip_ok_i   (skip_w[g]),
            .trig_o      (trig_w[g]),
            .work_o      (work_w[g]),
            .err_o       (err_w[g])
        );
    end

    assign trig_a  = trig_w[0];
    assign trig_b  = trig_w[1];
    assign cfg_err = err_w[0] | err_w[1];

    AST_ERR_NEEDS_TIE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (cfg_w[0].tied || cfg_w[1].tied)) else $error("error flag without tie"); // R9

    AST_PLAIN_BAD_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!comp_mode && ctrl.sel[1] && !load_w[0]) |=> $stable(work_w[0])) else $error("illegal select reloaded"); // R6

endmodule

// File: tb/adc_trig_gen_tb.sv
module adc_trig_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        comp_mode = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_up = 1'b1;
    logic [15:0] crest_val = 16'd10;
    logic        crest_stb = 1'b0, trough_stb = 1'b0, period_stb = 1'b0;
    logic        skip_ok_a = 1'b0, skip_ok_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trig_a, trig_b, cfg_err;

    adc_trig_gen u_dut (
        .clk(clk), .rst(rst), .comp_mode(comp_mode), .cnt_val(cnt_val),
        .cnt_up(cnt_up), .crest_val(crest_val), .crest_stb(crest_stb),
        .trough_stb(trough_stb), .period_stb(period_stb),
        .skip_ok_a(skip_ok_a), .skip_ok_b(skip_ok_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .trig_a(trig_a), .trig_b(trig_b), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    bit rnd_wr = 0;
    int pulses_a = 0, pulses_b = 0;

    logic [15:0] m_ctrl = '0;
    logic [15:0] m_buf  [2] = '{16'd0, 16'd0};
    logic [15:0] m_work [2] = '{16'd0, 16'd0};

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit f_hit(int ch);
        bit up_en, dn_en, tied, win, sk;
        int cnt, cr;
        up_en = m_ctrl[7 - 2*ch];
        dn_en = m_ctrl[6 - 2*ch];
        tied  = (ch == 0) ? |m_ctrl[3:2] : |m_ctrl[1:0];
        sk    = (ch == 0) ? skip_ok_a : skip_ok_b;
        cnt   = int'(cnt_val);
        cr    = int'(crest_val);
        if (comp_mode)
            win = (up_en && cnt_up && cnt <= cr - 1) || (dn_en && !cnt_up && cnt >= 1 && cnt <= cr);
        else
            win = up_en;
        return win && (cnt_val == m_work[ch]) && (!tied || sk);
    endfunction

    function automatic bit f_reload();
        logic [1:0] s = m_ctrl[15:14];
        if (comp_mode)
            return (s == 2'b01 && crest_stb) || (s == 2'b10 && trough_stb) ||
                   (s == 2'b11 && (crest_stb || trough_stb));
        return (s == 2'b01) && period_stb;
    endfunction

    function automatic bit f_err();
        bit e = 0;
        for (int ch = 0; ch < 2; ch++) begin
            bit tied = (ch == 0) ? |m_ctrl[3:2] : |m_ctrl[1:0];
            if (tied && (int'(m_work[ch]) < 2 || int'(m_work[ch]) + 2 > int'(crest_val))) e = 1;
        end
        return e;
    endfunction

    // One clock: predict, advance the model, sample at the falling edge.
    task automatic step();
        bit ea, eb, rl;
        logic [15:0] ob [2];
        if (rnd_wr && ($urandom % 8) == 0) begin
            wr_en   = 1'b1;
            wr_addr = 3'($urandom % 5);
            wr_data = (wr_addr == 3'd0) ? 16'($urandom) : 16'($urandom % (int'(crest_val) + 2));
        end
        ea = f_hit(0);
        eb = f_hit(1);
        rl = f_reload();
        ob = m_buf;
        if (rl) begin
            m_work[0] = ob[0];
            m_work[1] = ob[1];
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: m_ctrl    = wr_data & 16'hC0FF;
                3'd1: m_buf[0]  = wr_data;
                3'd2: m_buf[1]  = wr_data;
                3'd3: m_work[0] = wr_data;
                3'd4: m_work[1] = wr_data;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(trig_a === ea, "R1 trig_a", int'(trig_a), int'(ea));
        chk(trig_b === eb, "R1 trig_b", int'(trig_b), int'(eb));
        chk(cfg_err === f_err(), "R9 cfg_err", int'(cfg_err), int'(f_err()));
        pulses_a += int'(trig_a);
        pulses_b += int'(trig_b);
    endtask

    task automatic put(logic [15:0] c, logic up, logic cs, logic ts, logic ps);
        cnt_val = c; cnt_up = up; crest_stb = cs; trough_stb = ts; period_stb = ps;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        put(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic rd_chk(logic [2:0] a, logic [15:0] exp, string req);
        rd_addr = a;
        #1;
        chk(rd_data === exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic tri_period(int cr);
        crest_val = 16'(cr);
        for (int v = 0; v < cr; v++) begin
            put(16'(v), 1'b1, 1'b0, v == 0, 1'b0);
            step();
        end
        for (int v = cr; v >= 1; v--) begin
            put(16'(v), 1'b0, v == cr, 1'b0, 1'b0);
            step();
        end
        put(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic saw_period(int cr, bit rising);
        crest_val = 16'(cr);
        for (int i = 0; i <= cr; i++) begin
            int v = rising ? i : cr - i;
            put(16'(v), rising, 1'b0, 1'b0, v == cr);
            step();
        end
        put(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(trig_a === 1'b0 && trig_b === 1'b0, "R11 trig after reset", int'(trig_a | trig_b), 0);
        chk(cfg_err === 1'b0, "R11 cfg_err after reset", int'(cfg_err), 0);
        for (int a = 0; a < 5; a++) rd_chk(3'(a), 16'h0000, "R11 register reset");

        // R10 / R12 register layout and readback
        wr(3'd0, 16'hFFFF);
        rd_chk(3'd0, 16'hC0FF, "R10 ctrl readback mask");
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h1234);
        rd_chk(3'd2, 16'h1234, "R12 buffer B readback");
        wr(3'd4, 16'h0007);
        rd_chk(3'd4, 16'h0007, "R12 working B readback");

        // R2 up window boundaries
        comp_mode = 1'b1; crest_val = 16'd10;
        wr(3'd0, 16'h0080);
        wr(3'd3, 16'd0);
        put(16'd0, 1'b1, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b1, "R2 up window at 0", int'(trig_a), 1);
        wr(3'd3, 16'd10);
        put(16'd10, 1'b1, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b0, "R2 up window excludes crest", int'(trig_a), 0);

        // R3 down window boundaries
        wr(3'd0, 16'h0040);
        put(16'd10, 1'b0, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b1, "R3 down window at crest", int'(trig_a), 1);
        wr(3'd3, 16'd0);
        put(16'd0, 1'b0, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b0, "R3 down window excludes 0", int'(trig_a), 0);

        // R4 plain mode
        comp_mode = 1'b0;
        wr(3'd0, 16'h00C0);
        wr(3'd3, 16'd5);
        put(16'd5, 1'b0, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b1, "R4 up enable matches counting down", int'(trig_a), 1);
        wr(3'd0, 16'h0040);
        put(16'd5, 1'b0, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b0, "R4 down enable ignored in plain", int'(trig_a), 0);

        // R6 plain reload selects
        wr(3'd1, 16'd7);
        wr(3'd3, 16'd3);
        wr(3'd0, 16'h8000);
        put(16'd0, 1'b1, 1'b0, 1'b1, 1'b1); step();
        rd_chk(3'd3, 16'd3, "R6 select 10 no reload in plain");
        wr(3'd0, 16'hC000);
        put(16'd0, 1'b1, 1'b1, 1'b1, 1'b1); step();
        rd_chk(3'd3, 16'd3, "R6 select 11 no reload in plain");
        wr(3'd0, 16'h4000);
        put(16'd9, 1'b1, 1'b0, 1'b0, 1'b1); step();
        rd_chk(3'd3, 16'd7, "R6 select 01 reload on period");

        // R5 complementary reload selects
        comp_mode = 1'b1;
        wr(3'd1, 16'd4);
        wr(3'd0, 16'h0000);
        put(16'd10, 1'b0, 1'b1, 1'b0, 1'b0); step();
        rd_chk(3'd3, 16'd7, "R5 select 00 holds");
        wr(3'd0, 16'hC000);
        put(16'd0, 1'b1, 1'b0, 1'b1, 1'b0); step();
        rd_chk(3'd3, 16'd4, "R5 select 11 reload at trough");
        wr(3'd1, 16'd6);
        wr(3'd0, 16'h8000);
        put(16'd10, 1'b0, 1'b1, 1'b0, 1'b0); step();
        rd_chk(3'd3, 16'd4, "R5 select 10 ignores crest");
        put(16'd0, 1'b1, 1'b0, 1'b1, 1'b0); step();
        rd_chk(3'd3, 16'd6, "R5 select 10 reloads at trough");

        // R12 write priority over reload
        wr(3'd1, 16'd8);
        put(16'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd2;
        step();
        rd_chk(3'd3, 16'd2, "R12 write beats reload");

        // R7 trough reload of 0 with up enable
        wr(3'd0, 16'h8080);
        wr(3'd1, 16'd5);
        wr(3'd3, 16'd5);
        pulses_a = 0; tri_period(10);
        chk(pulses_a == 1, "R7 trough base period", pulses_a, 1);
        wr(3'd1, 16'd0);
        pulses_a = 0; tri_period(10);
        chk(pulses_a == 0, "R7 trough reload of 0 misses", pulses_a, 0);
        pulses_a = 0; tri_period(10);
        chk(pulses_a == 1, "R7 trough following period fires", pulses_a, 1);

        // R7 crest reload of crest value with down enable
        wr(3'd0, 16'h4040);
        wr(3'd1, 16'd5);
        wr(3'd3, 16'd5);
        wr(3'd1, 16'd10);
        pulses_a = 0; tri_period(10);
        chk(pulses_a == 0, "R7 crest reload of crest misses", pulses_a, 0);
        pulses_a = 0; tri_period(10);
        chk(pulses_a == 1, "R7 crest following period fires", pulses_a, 1);

        // R8 qualify gating
        wr(3'd0, 16'h0088);
        wr(3'd3, 16'd5);
        skip_ok_a = 1'b0;
        put(16'd5, 1'b1, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b0, "R8 tied without qualify", int'(trig_a), 0);
        skip_ok_a = 1'b1;
        put(16'd5, 1'b1, 1'b0, 1'b0, 1'b0); step();
        chk(trig_a === 1'b1, "R8 tied with qualify", int'(trig_a), 1);

        // R9 range edges (crest 10, channel A tied)
        wr(3'd3, 16'd1);
        chk(cfg_err === 1'b1, "R9 value 1 flagged", int'(cfg_err), 1);
        wr(3'd3, 16'd2);
        chk(cfg_err === 1'b0, "R9 value 2 accepted", int'(cfg_err), 0);
        wr(3'd3, 16'd8);
        chk(cfg_err === 1'b0, "R9 value crest-2 accepted", int'(cfg_err), 0);
        wr(3'd3, 16'd9);
        chk(cfg_err === 1'b1, "R9 value crest-1 flagged", int'(cfg_err), 1);

        // Random periods, model-checked every cycle (R1..R9)
        rnd_wr = 1;
        for (int p = 0; p < 150; p++) begin
            int cr = 4 + int'($urandom % 12);
            skip_ok_a = 1'($urandom);
            skip_ok_b = 1'($urandom);
            comp_mode = ($urandom % 4) != 0;
            if (comp_mode) tri_period(cr);
            else saw_period(cr, 1'($urandom));
        end
        rnd_wr = 0;

        finished = 1;
        report();
    end

endmodule